// File: doc/BRIEF.md
# Soft Reset and NMI Exception Controller

This block decides when a processor core takes one of its non-maskable, reset-class exceptions. A power-on (cold) reset puts the whole controller in a known state. On the first clock after the cold reset is released, the controller loads configuration, clears the core's state machines and sends fetch to the reset handler. After that, two sources share one soft-reset exception path: a warm reset pin and a non-maskable interrupt (NMI). The NMI can come from a pin, or from a bus write that sets the NMI bit of the interrupt register. Both sources redirect fetch to the same uncached, unmapped handler vector. Both also set a sticky status flag, which software reads to tell a soft reset from a cold one. Nothing the controller exposes shows which of the two sources caused the exception.

The two sources differ in how hard they hit the core. A warm reset is taken on any cycle and in any core state. It clears the state machines and aborts any multicycle operation in flight, but it never reloads configuration. An NMI is held pending until the core is executing instructions and sits at an instruction boundary. It is then taken without clearing or aborting anything, so the machine state stays available for diagnosis.

Top module: `softrst_ctrl`

## Requirements
- R1: While `cold_rst_n` is low, `cfg_load`, `sm_clear`, `pipe_abort`, `redirect_valid` and `status_sr` are all 0.
- R2: On the first clock edge after `cold_rst_n` rises, `cfg_load`, `sm_clear` and `redirect_valid` pulse high together for exactly one cycle, and `status_sr` stays 0. `cfg_load` is never asserted at any other time.
- R3: A falling edge on `warm_rst_n` passes through a two-flop synchronizer. The third rising clock edge after the input falls registers a one-cycle pulse on `sm_clear`, `pipe_abort` and `redirect_valid`, and sets `status_sr`. This happens whatever the values of `core_running`, `core_at_boundary` and `core_mc_busy`.
- R4: Holding `warm_rst_n` low gives exactly one warm exception. If `warm_rst_n` is already low when the cold reset is released, it gives no warm exception.
- R5: A falling edge on `nmi_n` (active low, two-flop synchronized) raises an NMI. With the core running and at a boundary, the NMI appears three clock edges after the input falls. It shows as a one-cycle `redirect_valid` pulse that sets `status_sr`, with `sm_clear` and `pipe_abort` both 0. A held-low `nmi_n` gives one NMI.
- R6: A cycle with `intreg_wr` high and bit 6 of `intreg_wdata` set raises an NMI in that cycle. If the core is running and at a boundary, `redirect_valid` pulses on the next edge. A write with bit 6 clear has no effect, whatever the other data bits are.
- R7: An NMI raised while `core_running` or `core_at_boundary` is low stays pending. It is taken exactly once, on the first cycle in which both are high. Several NMIs raised while one is already pending are merged into that one exception.
- R8: If a warm reset is taken while an NMI is pending, or in the same cycle an NMI is raised, the warm reset wins. The NMI is discarded and never produces a redirect.
- R9: `status_sr` stays set until the next cold reset, and it is set the same way by both causes.
- R10: `redirect_pc` always carries the handler vector `32'hBFC0_0000`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| cold_rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| warm_rst_n | input | 1 | Warm reset request, active low, asynchronous |
| nmi_n | input | 1 | Non-maskable interrupt pin, active low, asynchronous |
| intreg_wr | input | 1 | Bus write strobe to the interrupt register |
| intreg_wdata | input | 8 | Bus write data; bit 6 requests an NMI |
| core_running | input | 1 | Core is executing instructions |
| core_at_boundary | input | 1 | Core is at an instruction boundary this cycle |
| core_mc_busy | input | 1 | A multicycle operation is in progress |
| cfg_load | output | 1 | One-cycle pulse: load configuration parameters |
| sm_clear | output | 1 | One-cycle pulse: clear core state machines and registers |
| pipe_abort | output | 1 | One-cycle pulse: abort operations in flight |
| redirect_valid | output | 1 | One-cycle pulse: redirect fetch to `redirect_pc` |
| redirect_pc | output | 32 | Reset handler vector |
| status_sr | output | 1 | Soft-reset status flag |

## Verification
The assertions check on every cycle the relations between the outputs. An abort always comes with a clear, a redirect and a set status flag. Configuration loads come as single pulses and never after a soft reset. The status flag never drops outside a cold reset. A redirect without a clear happens only when the previous cycle had the core running at a boundary. Other behaviour needs the bench's timed scenarios to show it: the three-edge synchronizer latency, a held NMI or warm level giving one event, NMIs waiting and merging while the core is away from a boundary, a warm reset discarding a pending NMI, and a warm level present at cold release being ignored.

// File: rtl/softrst_pkg.sv
package softrst_pkg;

    localparam logic [31:0] HANDLER_VEC_DEFAULT = 32'hBFC0_0000;

    typedef enum logic {
        PH_INIT   = 1'b0,
        PH_ACTIVE = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   cfg_load;
        logic   sm_clear;
        logic   abort;
        logic   redirect;
        logic   sr;
    } seq_state_t;

    typedef struct packed {
        logic pend;
    } nmi_state_t;

endpackage

// File: rtl/softrst_sync.sv
module softrst_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= RST_VAL;
                    else        chain_q[i] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= RST_VAL;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/softrst_fall_detect.sv
module softrst_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fall
);
    // Previous level resets to the asserted (low) value, so a line that is
    // already low when reset is released produces no edge.
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign fall = prev_q & ~level;
endmodule

// File: rtl/softrst_nmi_queue.sv
module softrst_nmi_queue #(
    parameter int INT_W   = 8,
    parameter int NMI_BIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             pin_evt,
    input  logic             wr,
    input  logic [INT_W-1:0] wdata,
    input  logic             take,
    input  logic             flush,
    output logic             pend_any
);
    import softrst_pkg::*;

    nmi_state_t st_d, st_q;
    logic       new_evt;

    always_comb begin
        new_evt  = armed & (pin_evt | (wr & wdata[NMI_BIT]));
        pend_any = st_q.pend | new_evt;
        st_d     = st_q;
        if (flush || take) begin
            st_d.pend = 1'b0;
        end else if (new_evt) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/softrst_seq.sv
module softrst_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic warm_evt,
    input  logic nmi_pend,
    input  logic core_running,
    input  logic core_at_boundary,
    output logic armed,
    output logic nmi_take,
    output logic nmi_flush,
    output logic cfg_load,
    output logic sm_clear,
    output logic abort,
    output logic redirect,
    output logic sr
);
    import softrst_pkg::*;

    seq_state_t st_d, st_q;
    logic       warm_go;
    logic       nmi_ok;

    always_comb begin
        st_d          = st_q;
        st_d.cfg_load = 1'b0;
        st_d.sm_clear = 1'b0;
        st_d.abort    = 1'b0;
        st_d.redirect = 1'b0;
        armed         = (st_q.phase == PH_ACTIVE);
        warm_go       = armed & warm_evt;
        nmi_ok        = armed & nmi_pend & core_running & core_at_boundary;
        nmi_take      = 1'b0;
        nmi_flush     = warm_go;

        unique case (st_q.phase)
            PH_INIT: begin
                st_d.cfg_load = 1'b1;
                st_d.sm_clear = 1'b1;
                st_d.redirect = 1'b1;
                st_d.phase    = PH_ACTIVE;
            end
            PH_ACTIVE: begin
                if (warm_go) begin
                    st_d.sm_clear = 1'b1;
                    st_d.abort    = 1'b1;
                    st_d.redirect = 1'b1;
                    st_d.sr       = 1'b1;
                end else if (nmi_ok) begin
                    st_d.redirect = 1'b1;
                    st_d.sr       = 1'b1;
                    nmi_take      = 1'b1;
                end
            end
            default: st_d.phase = PH_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_INIT, default: 1'b0};
        else        st_q <= st_d;
    end

    assign cfg_load = st_q.cfg_load;
    assign sm_clear = st_q.sm_clear;
    assign abort    = st_q.abort;
    assign redirect = st_q.redirect;
    assign sr       = st_q.sr;
endmodule

// File: rtl/softrst_ctrl.sv
module softrst_ctrl #(
    parameter int          SYNC_STAGES = 2,
    parameter int          INT_W       = 8,
    parameter int          NMI_BIT     = 6,
    parameter logic [31:0] HANDLER_VEC = softrst_pkg::HANDLER_VEC_DEFAULT
) (
    input  logic             clk,
    input  logic             cold_rst_n,
    input  logic             warm_rst_n,
    input  logic             nmi_n,
    input  logic             intreg_wr,
    input  logic [INT_W-1:0] intreg_wdata,
    input  logic             core_running,
    input  logic             core_at_boundary,
    input  logic             core_mc_busy,
    output logic             cfg_load,
    output logic             sm_clear,
    output logic             pipe_abort,
    output logic             redirect_valid,
    output logic [31:0]      redirect_pc,
    output logic             status_sr
);
    logic warm_s, nmi_s;
    logic warm_evt, nmi_pin_evt;
    logic armed, nmi_pend, nmi_take, nmi_flush;
    logic busy_unused;

    // The abort is issued on every warm reset; the busy level needs no gating.
    assign busy_unused = core_mc_busy;

    softrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_warm_sync (
        .clk(clk), .rst_n(cold_rst_n), .d(warm_rst_n), .q(warm_s)
    );

    softrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_nmi_sync (
        .clk(clk), .rst_n(cold_rst_n), .d(nmi_n), .q(nmi_s)
    );

    softrst_fall_detect u_warm_edge (
        .clk(clk), .rst_n(cold_rst_n), .level(warm_s), .fall(warm_evt)
    );

    softrst_fall_detect u_nmi_edge (
        .clk(clk), .rst_n(cold_rst_n), .level(nmi_s), .fall(nmi_pin_evt)
    );

    softrst_nmi_queue #(.INT_W(INT_W), .NMI_BIT(NMI_BIT)) u_nmiq (
        .clk      (clk),
        .rst_n    (cold_rst_n),
        .armed    (armed),
        .pin_evt  (nmi_pin_evt),
        .wr       (intreg_wr),
        .wdata    (intreg_wdata),
        .take     (nmi_take),
        .flush    (nmi_flush),
        .pend_any (nmi_pend)
    );

    softrst_seq u_seq (
        .clk              (clk),
        .rst_n            (cold_rst_n),
        .warm_evt         (warm_evt),
        .nmi_pend         (nmi_pend),
        .core_running     (core_running),
        .core_at_boundary (core_at_boundary),
        .armed            (armed),
        .nmi_take         (nmi_take),
        .nmi_flush        (nmi_flush),
        .cfg_load         (cfg_load),
        .sm_clear         (sm_clear),
        .abort            (pipe_abort),
        .redirect         (redirect_valid),
        .sr               (status_sr)
    );

    assign redirect_pc = HANDLER_VEC;
endmodule

// File: rtl/softrst_ctrl_chk.sv
module softrst_ctrl_chk (
    input logic clk,
    input logic cold_rst_n,
    input logic core_running,
    input logic core_at_boundary,
    input logic cfg_load,
    input logic sm_clear,
    input logic pipe_abort,
    input logic redirect_valid,
    input logic status_sr
);
    p_abort_full_r3: assert property (@(posedge clk) disable iff (!cold_rst_n)
        pipe_abort |-> (sm_clear && redirect_valid && status_sr));

    p_cfg_cold_only_r2: assert property (@(posedge clk) disable iff (!cold_rst_n)
        cfg_load |-> (!status_sr && !pipe_abort));

    p_cfg_single_r2: assert property (@(posedge clk) disable iff (!cold_rst_n)
        cfg_load |=> !cfg_load);

    p_sr_sticky_r9: assert property (@(posedge clk) disable iff (!cold_rst_n)
        status_sr |=> status_sr);

    p_nmi_boundary_r5: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (redirect_valid && !sm_clear) |-> $past(core_running && core_at_boundary));

    p_redirect_flag_r9: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (redirect_valid && !cfg_load) |-> status_sr);
endmodule

bind softrst_ctrl softrst_ctrl_chk u_chk (
    .clk              (clk),
    .cold_rst_n       (cold_rst_n),
    .core_running     (core_running),
    .core_at_boundary (core_at_boundary),
    .cfg_load         (cfg_load),
    .sm_clear         (sm_clear),
    .pipe_abort       (pipe_abort),
    .redirect_valid   (redirect_valid),
    .status_sr        (status_sr)
);

// File: tb/softrst_ctrl_test.sv
module softrst_ctrl_test;
    localparam int          CLK_PERIOD = 10;
    localparam int          WD_CYCLES  = 20000;
    localparam logic [31:0] VEC        = 32'hBFC0_0000;

    // Row bits: [5] write, [4] bit6, [3] running, [2] boundary,
    //           [1] expected redirect, [0] expected status flag
    localparam logic [5:0] TBL [0:11] = '{
        6'b001100, 6'b101100, 6'b111111, 6'b001101,
        6'b111001, 6'b000101, 6'b001111, 6'b001101,
        6'b110001, 6'b110001, 6'b001111, 6'b001101
    };

    logic        clk = 1'b0;
    logic        cold_rst_n = 1'b0;
    logic        warm_rst_n = 1'b1;
    logic        nmi_n = 1'b1;
    logic        intreg_wr = 1'b0;
    logic [7:0]  intreg_wdata = 8'h00;
    logic        core_running = 1'b1;
    logic        core_at_boundary = 1'b1;
    logic        core_mc_busy = 1'b0;
    logic        cfg_load, sm_clear, pipe_abort, redirect_valid, status_sr;
    logic [31:0] redirect_pc;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    softrst_ctrl uut (
        .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n), .nmi_n(nmi_n),
        .intreg_wr(intreg_wr), .intreg_wdata(intreg_wdata),
        .core_running(core_running), .core_at_boundary(core_at_boundary),
        .core_mc_busy(core_mc_busy), .cfg_load(cfg_load), .sm_clear(sm_clear),
        .pipe_abort(pipe_abort), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .status_sr(status_sr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // outputs packed {cfg_load, sm_clear, pipe_abort, redirect_valid, status_sr}
    function automatic logic [4:0] outs();
        return {cfg_load, sm_clear, pipe_abort, redirect_valid, status_sr};
    endfunction

    task automatic cold_cycle();
        cold_rst_n = 1'b0;
        step(2);
        chk("R1 outputs in reset", {27'd0, outs()}, 32'h0);
        cold_rst_n = 1'b1;
        step(1);
        chk("R2 init pulse", {27'd0, outs()}, 32'b11010);
        step(1);
        chk("R2 init pulse ends", {27'd0, outs()}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        // R1 / R2 / R10
        cold_cycle();
        chk("R10 vector", redirect_pc, VEC);

        // Table: bus-written NMI (R6, R7, R9)
        for (int i = 0; i < 12; i++) begin
            intreg_wr        = TBL[i][5];
            intreg_wdata     = TBL[i][4] ? 8'h40 : 8'hBF;
            core_running     = TBL[i][3];
            core_at_boundary = TBL[i][2];
            step(1);
            chk($sformatf("R6 R7 redirect row %0d", i), {31'd0, redirect_valid}, {31'd0, TBL[i][1]});
            chk($sformatf("R9 flag row %0d", i), {31'd0, status_sr}, {31'd0, TBL[i][0]});
            chk($sformatf("R5 no clear row %0d", i), {30'd0, sm_clear, pipe_abort}, 32'd0);
        end
        intreg_wr = 1'b0;

        // R9: cold reset clears the flag
        cold_cycle();

        // R3 / R4: warm reset with the core halted and busy
        core_running = 1'b0; core_at_boundary = 1'b0; core_mc_busy = 1'b1;
        warm_rst_n = 1'b0;
        step(2);
        chk("R3 latency", {27'd0, outs()}, 32'h0);
        step(1);
        chk("R3 warm pulse", {27'd0, outs()}, 32'b01111);
        chk("R10 vector on warm", redirect_pc, VEC);
        step(1);
        chk("R3 warm pulse ends", {27'd0, outs()}, 32'b00001);
        step(6);
        chk("R4 held warm once", {27'd0, outs()}, 32'b00001);
        warm_rst_n = 1'b1;
        core_mc_busy = 1'b0;
        step(4);

        // R5: NMI pin, running at boundary
        cold_cycle();
        core_running = 1'b1; core_at_boundary = 1'b1;
        nmi_n = 1'b0;
        step(2);
        chk("R5 latency", {27'd0, outs()}, 32'h0);
        step(1);
        chk("R5 nmi pulse", {27'd0, outs()}, 32'b00011);
        step(1);
        chk("R5 nmi pulse ends", {27'd0, outs()}, 32'b00001);
        step(5);
        chk("R5 held nmi once", {27'd0, outs()}, 32'b00001);
        nmi_n = 1'b1;
        step(4);

        // R8: warm reset discards a pending NMI
        cold_cycle();
        core_at_boundary = 1'b0;
        intreg_wr = 1'b1; intreg_wdata = 8'h40;
        step(1);
        intreg_wr = 1'b0;
        chk("R8 nmi pending, no redirect", {31'd0, redirect_valid}, 32'd0);
        warm_rst_n = 1'b0;
        step(3);
        chk("R8 warm wins", {27'd0, outs()}, 32'b01111);
        step(1);
        core_at_boundary = 1'b1;
        begin
            int seen = 0;
            for (int k = 0; k < 6; k++) begin
                step(1);
                if (redirect_valid) seen++;
            end
            chk("R8 pending nmi discarded", seen, 0);
        end
        warm_rst_n = 1'b1;
        step(4);

        // R4: warm low already at cold release is ignored
        warm_rst_n = 1'b0;
        cold_cycle();
        begin
            int clr = 0;
            for (int k = 0; k < 6; k++) begin
                step(1);
                if (sm_clear || status_sr) clr++;
            end
            chk("R4 warm before cold done ignored", clr, 0);
        end
        warm_rst_n = 1'b1;
        step(3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule